// File: doc/BRIEF.md
# Delayed Interrupt-Enable Controller

This block holds the interrupt master-enable and the latched interrupt requests of a small 8-bit processor core. The instruction decoder gives it three strobes: one for the enable instruction, one for the disable instruction, and one that marks the last cycle of every instruction. Peripherals raise request bits that stay latched. A mask input selects which of them may interrupt. At each instruction end the block decides whether to interrupt. When it does, it sends the sequencer a one-cycle acknowledge with a vector address, clears the serviced request bit and drops the master enable.

The enable instruction is delayed by one instruction. It arms a pending-enable stage, and that stage opens the gate only at the next instruction end. An enable followed at once by a disable therefore lets nothing through. An enable followed by any other instruction lets a waiting request be serviced at the end of that instruction. The disable instruction acts at once. The latched request flags are visible on an output, so that the register file can present them to software as a readable register.

The decoder asserts the enable and disable strobes in the final cycle of their instruction, which is the same cycle as the instruction-end strobe.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, `req_flags` is 0, `master_en` is 0 and `irq_ack` is 0.
- R2: A bit raised on `req_raise` shows in `req_flags` after the next clock edge. It stays set until that bit is serviced, whether or not interrupts are enabled.
- R3: An enable instruction followed directly by a disable instruction causes no acknowledge at either instruction end. The disable also cancels the pending enable, so later instruction ends take nothing either.
- R4: After an enable instruction, `master_en` is still 0 following that instruction's end. If a request is active at the end of the next instruction, it is serviced there. If no request is active, `master_en` reads 1 after that next instruction end.
- R5: A disable instruction clears `master_en` at its own instruction end, and no interrupt is taken at that end or at any later one.
- R6: The active set is `req_flags & req_mask`, and its lowest-numbered set bit wins. A bit whose mask is 0 is never serviced.
- R7: `irq_ack` is a single-cycle pulse in the cycle after the deciding instruction end. In that cycle `irq_vector` is 0x40 + 8 × (index of the winning bit), so bit 0 gives 0x40 and bit 7 gives 0x78.
- R8: Servicing clears `master_en`, the pending enable and the winning request bit. The other request bits are left as they were.
- R9: Interrupts are decided only in a cycle where `insn_end` is 1. An enabled and active request does not produce an acknowledge until the next instruction end.
- R10: If the bit being serviced is raised again in the deciding cycle, the bit still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | Last cycle of the current instruction |
| en_stb | input | 1 | Enable instruction (asserted together with insn_end) |
| dis_stb | input | 1 | Disable instruction (asserted together with insn_end) |
| req_raise | input | 8 | Per-source request set pulses |
| req_mask | input | 8 | Per-source request enable |
| req_flags | output | 8 | Latched request bits |
| master_en | output | 1 | Interrupt master enable |
| irq_ack | output | 1 | Interrupt taken, one-cycle pulse |
| irq_vector | output | 8 | Handler address for the taken interrupt |

## Verification
The bench targets the one-instruction enable delay. An enable followed directly by a disable must stay silent, while an enable followed by one other instruction must service the request. A design that opened the gate at once, or two instructions late, would acknowledge in the first case or miss the second. The bench also checks that a masked higher-priority bit is skipped and that the lowest active bit wins, which catches a reversed priority encoder or a mask that is ignored. It further raises the serviced bit in the same cycle it is cleared, and it holds a fully enabled request until the next instruction end, which exposes a design that decides outside instruction ends.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int VEC_W = 8;

    typedef struct packed {
        logic ime;
        logic pend;
    } en_state_t;

    typedef struct packed {
        logic             ack;
        logic [VEC_W-1:0] vec;
    } ack_state_t;

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_SRC = 8,
    localparam int IW = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] active,
    output logic             any,
    output logic [IW-1:0]    idx,
    output logic [N_SRC-1:0] grant
);

    logic [N_SRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chain
        assign grant[i]  = active[i] & ~seen[i];
        assign seen[i+1] = seen[i] | active[i];
    end

    assign any = seen[N_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (active != '0) |-> ($countones(grant) == 1)); // R6

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic take,
    output logic en_eff,
    output logic master_en
);

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take || dis_stb) begin
            st_d = '0;
        end else begin
            if (insn_end) begin
                st_d.ime  = st_q.ime | st_q.pend;
                st_d.pend = 1'b0;
            end
            if (en_stb) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_eff    = st_q.ime | st_q.pend;
    assign master_en = st_q.ime;

    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb || dis_stb) |-> insn_end); // R3
    AST_DELAYED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ime) |-> $past(st_q.pend)); // R4
    AST_DISABLE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> (!st_q.ime && !st_q.pend)); // R5

endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raise,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] req_q
);

    logic [N_SRC-1:0] req_d;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_comb begin
            if (clr[i]) req_d[i] = 1'b0;
            else        req_d[i] = req_q[i] | raise[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(req_q) & ~$past(clr)) & ~req_q) == '0)); // R2
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & $past(clr)) == '0)); // R10

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irqc_pkg::*;
#(
    parameter int              N_SRC    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
    parameter int              VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_end,
    input  logic             en_stb,
    input  logic             dis_stb,
    input  logic [N_SRC-1:0] req_raise,
    input  logic [N_SRC-1:0] req_mask,
    output logic [N_SRC-1:0] req_flags,
    output logic             master_en,
    output logic             irq_ack,
    output logic [VEC_W-1:0] irq_vector
);

    localparam int IW = $clog2(N_SRC);

    logic             en_eff;
    logic             any;
    logic             take;
    logic [IW-1:0]    idx;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] clr;
    ack_state_t       ak_d, ak_q;

    irqc_req #(.N_SRC(N_SRC)) i_req (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (req_raise),
        .clr   (clr),
        .req_q (req_flags)
    );

    irqc_prio #(.N_SRC(N_SRC)) i_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (req_flags & req_mask),
        .any    (any),
        .idx    (idx),
        .grant  (grant)
    );

    irqc_enable i_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_end  (insn_end),
        .en_stb    (en_stb),
        .dis_stb   (dis_stb),
        .take      (take),
        .en_eff    (en_eff),
        .master_en (master_en)
    );

    assign take = insn_end & ~dis_stb & en_eff & any;
    assign clr  = take ? grant : '0;

    always_comb begin
        ak_d     = ak_q;
        ak_d.ack = take;
        if (take) ak_d.vec = VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ak_q <= '0;
        else        ak_q <= ak_d;
    end

    assign irq_ack    = ak_q.ack;
    assign irq_vector = ak_q.vec;

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack); // R7
    AST_ACK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(insn_end)); // R9
    AST_ACK_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !master_en); // R8
    AST_VEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_vector >= VEC_BASE)); // R7
    AST_NO_ACK_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> !irq_ack); // R5

endmodule

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       insn_end, en_stb, dis_stb;
    logic [7:0] req_raise, req_mask;
    logic [7:0] req_flags, irq_vector;
    logic       master_en, irq_ack;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_gate_ctrl i_irq_gate_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_end   (insn_end),
        .en_stb     (en_stb),
        .dis_stb    (dis_stb),
        .req_raise  (req_raise),
        .req_mask   (req_mask),
        .req_flags  (req_flags),
        .master_en  (master_en),
        .irq_ack    (irq_ack),
        .irq_vector (irq_vector)
    );

    typedef struct packed {
        logic       ei;
        logic       di;
        logic       iend;
        logic [7:0] raise;
        logic [7:0] mask;
        logic       ack;
        logic [7:0] vec;
        logic [7:0] flags;
        logic       me;
        logic [3:0] req;
    } row_t;

    localparam int NROW = 27;
    // ei di end raise mask | ack vec flags me | requirement
    localparam row_t TBL [NROW] = '{
        '{1'b0, 1'b0, 1'b0, 8'h04, 8'hFF, 1'b0, 8'h00, 8'h04, 1'b0, 4'd2},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h04, 1'b0, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h04, 1'b0, 4'd4},
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h04, 1'b0, 4'd3},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h04, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h50, 8'h00, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 8'h30, 8'hDF, 1'b0, 8'h00, 8'h30, 1'b0, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hDF, 1'b0, 8'h00, 8'h30, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hDF, 1'b1, 8'h60, 8'h20, 1'b0, 4'd8},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hDF, 1'b0, 8'h00, 8'h20, 1'b0, 4'd6},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hDF, 1'b0, 8'h00, 8'h20, 1'b1, 4'd6},
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h20, 1'b1, 4'd9},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h68, 8'h00, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 8'h81, 8'hFF, 1'b0, 8'h00, 8'h81, 1'b0, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h81, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h01, 8'hFF, 1'b1, 8'h40, 8'h80, 1'b0, 4'd10},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h80, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h78, 8'h00, 1'b0, 4'd7},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b1, 4'd4},
        '{1'b0, 1'b0, 1'b0, 8'h02, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b1, 4'd9},
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b0, 4'd5},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b0, 4'd4},
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b0, 4'd3},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b0, 4'd3}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ei, input logic di, input logic iend,
                         input logic [7:0] raise, input logic [7:0] mask);
        en_stb    = ei;
        dis_stb   = di;
        insn_end  = iend;
        req_raise = raise;
        req_mask  = mask;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R1: reset state
        check("R1", "req_flags", req_flags, 8'h00);
        check("R1", "master_en", {7'd0, master_en}, 8'h00);
        check("R1", "irq_ack", {7'd0, irq_ack}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", TBL[i].req, i);
            drive(TBL[i].ei, TBL[i].di, TBL[i].iend, TBL[i].raise, TBL[i].mask);
            check(tag, "irq_ack", {7'd0, irq_ack}, {7'd0, TBL[i].ack});
            if (TBL[i].ack) check(tag, "irq_vector", irq_vector, TBL[i].vec);
            check(tag, "req_flags", req_flags, TBL[i].flags);
            check(tag, "master_en", {7'd0, master_en}, {7'd0, TBL[i].me});
        end

        // R8: servicing leaves the other bits alone
        drive(1'b0, 1'b0, 1'b0, 8'h0C, 8'hFF);      // flags 0x0E
        drive(1'b1, 1'b0, 1'b1, 8'h00, 8'hFF);
        drive(1'b0, 1'b0, 1'b1, 8'h00, 8'hFF);      // bit 1 taken
        check("R8", "irq_vector", irq_vector, 8'h48);
        check("R8", "req_flags", req_flags, 8'h0C);
        check("R8", "master_en", {7'd0, master_en}, 8'h00);
        // R8: pending enable was cleared too, so the next end takes nothing
        drive(1'b0, 1'b0, 1'b1, 8'h00, 8'hFF);
        check("R8", "irq_ack", {7'd0, irq_ack}, 8'h00);

        // R1: reset from a busy state clears everything
        drive(1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 8'h00, 8'h00);      // master_en now 1
        check("R4", "master_en", {7'd0, master_en}, 8'h01);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        check("R1", "req_flags", req_flags, 8'h00);
        check("R1", "master_en", {7'd0, master_en}, 8'h00);
        check("R1", "irq_ack", {7'd0, irq_ack}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule